// File: doc/BRIEF.md
# Display Link Wake-up Controller

This block sits on the display side of a serial host link. It lets the display ask for the link to come out of hibernation at a known point in the panel refresh, so that new pixel data arrives without tearing. The host loads one configuration word before it lets the link sleep. That word holds an arm bit for refresh-timed wake-up, a frame count and a line count. When the link-active input falls, the block counts frame-start pulses and then line-start pulses from the timing generator. At the programmed point it raises a wake request toward the link client.

A second wake source is an external pin interrupt. It is accepted only when both its enable bit and its input-mode bit are set. The pin is synchronised and edge-detected, and an accepted edge sets an internal wake flag that raises the same request. Whichever source raised the request, it drops when the link reports active again. At that moment the hardware also clears the refresh arm bit and the pin flag. The host does not have to write anything.

Top module: `link_wake_ctrl`

## Requirements
- R1: After reset `clientWake` is low and `cfgRdata` reads all zeros.
- R2: A write with `cfgWe` high loads the configuration word. Bit 0 is the refresh arm bit, bit 1 the pin interrupt enable and bit 2 the pin input-mode bit. Bits [6:3] hold the frame count and bits [15:7] the line count. `cfgRdata` returns the same layout with the pin wake flag in bit 16, and it does so combinationally.
- R3: While `linkActive` stays high, frame and line pulses never raise `clientWake`, and the arm bit keeps its value.
- R4: Counting starts on a falling `linkActive` while the block is armed. With frame count F, line-start pulses are ignored until the (F+1)-th frame-start pulse after the fall.
- R5: With line count 0, `clientWake` is high right after the clock edge that samples that (F+1)-th frame-start pulse.
- R6: With line count L > 0, `clientWake` goes high right after the edge that samples the L-th line-start pulse following that frame start, and not earlier.
- R7: While the request is high, a high `linkActive` drops `clientWake` after the next edge. The same edge clears the arm bit and the pin wake flag.
- R8: If `linkActive` returns high during counting, no request is raised and the arm bit is cleared.
- R9: A rising edge on `pinIrq` sets the pin wake flag only when both the pin enable bit and the input-mode bit are set. Otherwise the flag stays 0 and no request is raised.
- R10: An accepted `pinIrq` rise raises `clientWake` exactly four clock edges after the pin changes. This comprises two synchroniser stages, the edge detect and the flag. A level held high raises only one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration word: arm, pin enable, pin input, frames, lines |
| cfgRdata | output | 17 | Configuration readback with the pin wake flag on top |
| linkActive | input | 1 | High while the serial link is awake |
| frameStart | input | 1 | One-cycle frame-start pulse |
| lineStart | input | 1 | One-cycle line-start pulse |
| pinIrq | input | 1 | Asynchronous external interrupt pin |
| clientWake | output | 1 | Wake request to the link client |

## Verification
The bench goes after the off-by-one edges of the count. One such edge is a frame count of zero, where the first frame start after sleep is already the target. Another is a line count of zero, where the request must rise on the frame start itself. A design that counted from one, or counted lines before the target frame, would raise the request a pulse early or late. Further checks cover an aborted sleep and a link that never slept. A design that got these wrong would either leave the arm bit set after a real hibernation or lose it when none happened. The pin path is checked for its exact latency, for gating by both enable bits, and for a held pin that must not re-trigger after the auto-clear.

// File: rtl/lwk_pkg.sv
package lwk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FRAMES = 2'd1,
    ST_LINES  = 2'd2,
    ST_WAKE   = 2'd3
  } wakeState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrFrame;
    logic incFrame;
    logic clrLine;
    logic incLine;
    logic clrSyncEn;
    logic clrPinFlag;
  } wakeStrobe_t;

  // conditions from the datapath to the sequencer
  typedef struct packed {
    logic syncEn;
    logic pinFlag;
    logic linkFall;
    logic frameHit;
    logic lineZero;
    logic lineLast;
  } wakeStatus_t;

endpackage

// File: rtl/lwk_datapath.sv
module lwk_datapath
  import lwk_pkg::*;
#(
  parameter int FRAME_W     = 4,
  parameter int LINE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [3+FRAME_W+LINE_W-1:0] cfgWdata,
  output logic [3+FRAME_W+LINE_W:0]   cfgRdata,
  input  logic                        linkActive,
  input  logic                        pinIrq,
  input  wakeStrobe_t                 strobe,
  output wakeStatus_t                 status
);

  localparam int FRAME_LSB = 3;
  localparam int LINE_LSB  = FRAME_LSB + FRAME_W;

  logic               syncEn;
  logic               irqEn;
  logic               pinIn;
  logic               pinFlag;
  logic [FRAME_W-1:0] frameCfg;
  logic [LINE_W-1:0]  lineCfg;
  logic [FRAME_W-1:0] frameSeen;
  logic [LINE_W-1:0]  lineSeen;
  logic               linkPrev;
  logic [SYNC_STAGES:0] pinSync;
  logic               pinRise;
  logic [LINE_W:0]    lineNext;

  // configuration bank; hardware clear of the arm bit wins over a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncEn   <= 1'b0;
      irqEn    <= 1'b0;
      pinIn    <= 1'b0;
      frameCfg <= '0;
      lineCfg  <= '0;
    end else begin
      if (strobe.clrSyncEn)  syncEn <= 1'b0;
      else if (cfgWe)        syncEn <= cfgWdata[0];
      if (cfgWe) begin
        irqEn    <= cfgWdata[1];
        pinIn    <= cfgWdata[2];
        frameCfg <= cfgWdata[FRAME_LSB +: FRAME_W];
        lineCfg  <= cfgWdata[LINE_LSB +: LINE_W];
      end
    end
  end

  // pin synchroniser chain plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= '0;
    else       pinSync <= {pinSync[SYNC_STAGES-1:0], pinIrq};
  end

  assign pinRise = pinSync[SYNC_STAGES-1] & ~pinSync[SYNC_STAGES];

  // pin wake flag: a new accepted edge wins over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          pinFlag <= 1'b0;
    else if (pinRise && irqEn && pinIn) pinFlag <= 1'b1;
    else if (strobe.clrPinFlag)         pinFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkPrev <= 1'b0;
    else       linkPrev <= linkActive;
  end

  // frame and line counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSeen <= '0;
      lineSeen  <= '0;
    end else begin
      if (strobe.clrFrame)      frameSeen <= '0;
      else if (strobe.incFrame) frameSeen <= frameSeen + 1'b1;
      if (strobe.clrLine)       lineSeen  <= '0;
      else if (strobe.incLine)  lineSeen  <= lineSeen + 1'b1;
    end
  end

  assign lineNext = {1'b0, lineSeen} + 1'b1;

  always_comb begin
    status.syncEn   = syncEn;
    status.pinFlag  = pinFlag;
    status.linkFall = linkPrev & ~linkActive;
    status.frameHit = (frameSeen == frameCfg);
    status.lineZero = (lineCfg == '0);
    status.lineLast = (lineNext == {1'b0, lineCfg});
  end

  assign cfgRdata = {pinFlag, lineCfg, frameCfg, pinIn, irqEn, syncEn};

  // R9
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinFlag) |-> $past(irqEn && pinIn));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (frameCfg == $past(cfgWdata[FRAME_LSB +: FRAME_W]) &&
               lineCfg  == $past(cfgWdata[LINE_LSB +: LINE_W])));

endmodule

// File: rtl/lwk_control.sv
module lwk_control
  import lwk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkActive,
  input  logic        frameStart,
  input  logic        lineStart,
  input  wakeStatus_t status,
  output wakeStrobe_t strobe,
  output logic        clientWake
);

  wakeState_t state;
  wakeState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (status.pinFlag) begin
          nextState = ST_WAKE;
        end else if (status.syncEn && status.linkFall) begin
          nextState       = ST_FRAMES;
          strobe.clrFrame = 1'b1;
        end
      end
      ST_FRAMES: begin
        if (status.pinFlag) begin
          nextState = ST_WAKE;
        end else if (linkActive) begin
          nextState        = ST_IDLE;
          strobe.clrSyncEn = 1'b1;
        end else if (frameStart) begin
          if (status.frameHit) begin
            if (status.lineZero) begin
              nextState = ST_WAKE;
            end else begin
              nextState      = ST_LINES;
              strobe.clrLine = 1'b1;
            end
          end else begin
            strobe.incFrame = 1'b1;
          end
        end
      end
      ST_LINES: begin
        if (status.pinFlag) begin
          nextState = ST_WAKE;
        end else if (linkActive) begin
          nextState        = ST_IDLE;
          strobe.clrSyncEn = 1'b1;
        end else if (lineStart) begin
          if (status.lineLast) nextState      = ST_WAKE;
          else                 strobe.incLine = 1'b1;
        end
      end
      ST_WAKE: begin
        if (linkActive) begin
          nextState         = ST_IDLE;
          strobe.clrSyncEn  = 1'b1;
          strobe.clrPinFlag = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign clientWake = (state == ST_WAKE);

  // R7
  wake_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE && linkActive) |=> (!clientWake && !status.syncEn));

  // R5
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clientWake) |-> $past(frameStart || lineStart || status.pinFlag));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_FRAMES || state == ST_LINES) && linkActive && !status.pinFlag)
      |=> (state == ST_IDLE && !clientWake));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !status.pinFlag) |=> !clientWake);

  // R4
  count_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.incFrame, strobe.clrLine, strobe.incLine, strobe.clrFrame}));

endmodule

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl
  import lwk_pkg::*;
#(
  parameter int FRAME_W     = 4,
  parameter int LINE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [3+FRAME_W+LINE_W-1:0] cfgWdata,
  output logic [3+FRAME_W+LINE_W:0]   cfgRdata,
  input  logic                        linkActive,
  input  logic                        frameStart,
  input  logic                        lineStart,
  input  logic                        pinIrq,
  output logic                        clientWake
);

  wakeStrobe_t strobe;
  wakeStatus_t status;

  lwk_datapath #(
    .FRAME_W    (FRAME_W),
    .LINE_W     (LINE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .cfgRdata  (cfgRdata),
    .linkActive(linkActive),
    .pinIrq    (pinIrq),
    .strobe    (strobe),
    .status    (status)
  );

  lwk_control ctl (
    .clk       (clk),
    .rstN      (rstN),
    .linkActive(linkActive),
    .frameStart(frameStart),
    .lineStart (lineStart),
    .status    (status),
    .strobe    (strobe),
    .clientWake(clientWake)
  );

endmodule

// File: tb/link_wake_ctrl_test.sv
module link_wake_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [16:0] cfgRdata;
  logic        linkActive = 1'b1;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic        pinIrq = 1'b0;
  logic        clientWake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  link_wake_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .linkActive(linkActive), .frameStart(frameStart),
    .lineStart(lineStart), .pinIrq(pinIrq), .clientWake(clientWake)
  );

  function automatic logic [15:0] mkCfg(bit arm, bit irq, bit pin,
                                        int frames, int lines);
    return {lines[8:0], frames[3:0], pin, irq, arm};
  endfunction

  // expected request after the k-th frame pulse (k from 0)
  function automatic bit wakeOnFrame(int k, int f, int l);
    return (k == f) && (l == 0);
  endfunction

  function automatic bit wakeOnLine(int k, int l);
    return k == l;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(logic [15:0] w);
    cfgWe = 1'b1; cfgWdata = w; tick(); cfgWe = 1'b0;
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1; tick(); frameStart = 1'b0;
  endtask

  task automatic pulseLine();
    lineStart = 1'b1; tick(); lineStart = 1'b0;
  endtask

  task automatic runTrial(int f, int l, int extra);
    writeCfg(mkCfg(1, 0, 0, f, l));
    linkActive = 1'b0; tick();
    chk("R4 no wake at sleep", clientWake, 0);
    for (int k = 0; k <= f; k++) begin
      pulseFrame();
      chk("R5 frame pulse", clientWake, wakeOnFrame(k, f, l));
      if (k < f) begin
        for (int e = 0; e < extra; e++) begin
          pulseLine();
          chk("R4 line before target frame", clientWake, 0);
        end
      end
    end
    for (int k = 1; k <= l; k++) begin
      pulseLine();
      chk("R6 line pulse", clientWake, wakeOnLine(k, l));
    end
    linkActive = 1'b1; tick();
    chk("R7 request released", clientWake, 0);
    chk("R7 arm cleared", cfgRdata[0], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #12 rstN = 1'b1;
    tick();
    // R1
    chk("R1 wake after reset", clientWake, 0);
    chk("R1 config after reset", cfgRdata, 0);

    // R2 readback layout
    writeCfg(mkCfg(0, 1, 0, 9, 300));
    chk("R2 readback", cfgRdata, {1'b0, 9'd300, 4'd9, 1'b0, 1'b1, 1'b0});

    // R3 link never sleeps
    writeCfg(mkCfg(1, 0, 0, 0, 0));
    for (int k = 0; k < 3; k++) begin
      pulseFrame(); pulseLine();
      chk("R3 no wake while active", clientWake, 0);
    end
    chk("R3 arm kept", cfgRdata[0], 1);

    // R5/R6 directed corners
    runTrial(0, 0, 0);
    runTrial(0, 1, 0);
    runTrial(3, 0, 2);
    runTrial(2, 5, 1);

    // constrained random trials
    for (int t = 0; t < 20; t++) begin
      int f = $urandom % 4;
      int l = $urandom % 6;
      int e = $urandom % 3;
      repeat ($urandom % 4) tick();
      runTrial(f, l, e);
    end

    // R8 abort during counting
    writeCfg(mkCfg(1, 0, 0, 2, 3));
    linkActive = 1'b0; tick();
    pulseFrame();
    linkActive = 1'b1; tick();
    chk("R8 no wake on abort", clientWake, 0);
    chk("R8 arm cleared on abort", cfgRdata[0], 0);
    pulseFrame(); pulseFrame(); pulseFrame();
    chk("R8 stays idle", clientWake, 0);

    // R9 gating
    linkActive = 1'b0; tick();
    writeCfg(mkCfg(0, 1, 0, 0, 0));
    pinIrq = 1'b1; repeat (6) tick();
    chk("R9 no wake without input mode", clientWake, 0);
    chk("R9 flag stays clear", cfgRdata[16], 0);
    pinIrq = 1'b0; repeat (3) tick();
    writeCfg(mkCfg(0, 0, 1, 0, 0));
    pinIrq = 1'b1; repeat (6) tick();
    chk("R9 no wake without enable", clientWake, 0);
    chk("R9 flag stays clear 2", cfgRdata[16], 0);
    pinIrq = 1'b0; repeat (3) tick();

    // R10 latency and single request
    writeCfg(mkCfg(0, 1, 1, 0, 0));
    pinIrq = 1'b1;
    repeat (3) tick();
    chk("R10 not yet after 3 edges", clientWake, 0);
    tick();
    chk("R10 wake after 4 edges", clientWake, 1);
    chk("R10 flag set", cfgRdata[16], 1);
    linkActive = 1'b1; tick();
    chk("R7 pin request released", clientWake, 0);
    chk("R7 pin flag cleared", cfgRdata[16], 0);
    repeat (6) tick();
    chk("R10 held pin no retrigger", clientWake, 0);
    pinIrq = 1'b0;
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule